// File: doc/BRIEF.md
# Snoopable Writeback Buffer

This block sits beside one cache and holds a single dirty victim line. The cache evicts a Modified line because a miss maps onto the same index. The line and its address are parked here while the cache controller sends the demand miss onto the bus. Only after the miss is out of the way does the buffer ask for the bus again, and it writes the victim back on the grant. Each miss therefore costs two bus transactions, and the miss always goes first.

While the line waits, other processors may ask for it. Every snooped request address is compared with the held line address, ignoring the byte offset within the line. On a match the buffer answers with the line itself and drops its own writeback, so memory is not written with data that has already moved to another cache. The buffer holds one line. While it is occupied it tells the cache to hold further evictions.

Top module: `wb_snoop_buffer`

## Requirements
- R1: After synchronous reset, `evict_stall`, `wb_req`, `wb_fire` and `snoop_hit` are all low.
- R2: An eviction offered while the buffer is empty is captured at that clock edge. From the next cycle `evict_stall` is high, and it stays high until the entry is released.
- R3: An eviction offered while `evict_stall` is high is ignored. The held address and data are unchanged, as seen later on `wb_addr`/`wb_data` or `snoop_data`.
- R4: `wb_req` is high only in a cycle that follows a cycle in which an entry was held and `miss_pending` was low. While `miss_pending` stays high, `wb_req` stays low.
- R5: A `wb_grant` in a cycle where `wb_req` is high completes the writeback. In the next cycle `wb_fire` pulses for one cycle. `wb_addr` then carries the held address with the offset bits forced to zero, and `wb_data` carries the held line. In that same cycle `evict_stall` and `wb_req` are low.
- R6: A snoop whose address matches the held line is answered in the next cycle. Only the address bits above the offset are compared; the offset is log2(LINE_BYTES) bits, 2 in the bench configuration. The answer is a one-cycle `snoop_hit` with `snoop_data` equal to the held line. The entry is released in that cycle, and no `wb_fire` follows for it.
- R7: A snoop to a different line, or any snoop while the buffer is empty, gives no `snoop_hit` and leaves the entry and its request state unchanged.
- R8: If a matching snoop and a `wb_grant` with `wb_req` high fall in the same cycle, the snoop is served (R6) and `wb_fire` stays low.
- R9: A `wb_grant` while `wb_req` is low has no effect: no `wb_fire`, and the entry is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Victim line offered by the cache |
| evict_addr | input | ADDR_W | Victim address |
| evict_data | input | LINE_BYTES*8 | Victim line contents |
| evict_stall | output | 1 | Entry occupied; hold further evictions |
| miss_pending | input | 1 | Demand miss not yet sent on the bus |
| wb_req | output | 1 | Bus request for the writeback |
| wb_grant | input | 1 | Bus grant for the writeback |
| wb_fire | output | 1 | One-cycle writeback transfer strobe |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_data | output | LINE_BYTES*8 | Writeback line data |
| snoop_valid | input | 1 | Remote request address present |
| snoop_addr | input | ADDR_W | Remote request address |
| snoop_hit | output | 1 | Buffer supplies the requested line |
| snoop_data | output | LINE_BYTES*8 | Line supplied to the remote requester |

## Verification
Two functions can fall in the same cycle: granting the writeback and serving a matching snoop. The bench waits until `wb_req` is high and then drives `wb_grant` and a matching `snoop_addr` together in one cycle. It judges the result by seeing `snoop_hit` with the correct line, `wb_fire` staying low in that cycle and the next, and the entry being released. Around this case, the snoop comparison is swept over every address in an 8-bit space against several held lines. Each sweep point expects a hit exactly when the upper six address bits agree.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_HOLD  = 2'd1,
    ST_REQ   = 2'd2
  } wbb_state_e;
endpackage

// File: rtl/wbb_line_match.sv
module wbb_line_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              entry_valid,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              match
);
  logic same_line;

  generate
    if (OFF_W > 0) begin : g_offset
      assign same_line = (entry_addr[ADDR_W-1:OFF_W] == probe_addr[ADDR_W-1:OFF_W]);
    end else begin : g_no_offset
      assign same_line = (entry_addr == probe_addr);
    end
  endgenerate

  assign match = entry_valid && probe_valid && same_line;
endmodule

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              supply,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data,
  output logic [DATA_W-1:0] supply_data
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] supply_q;

  // Data path without reset so it maps onto plain fabric registers or RAM.
  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= load_addr & ~OFF_MASK;
      data_q <= load_data;
    end
    if (supply) begin
      supply_q <= data_q;
    end
  end

  assign held_addr   = addr_q;
  assign held_data   = data_q;
  assign supply_data = supply_q;
endmodule

// File: rtl/wbb_ctrl.sv
module wbb_ctrl
  import wbb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evict_valid,
  input  logic miss_pending,
  input  logic wb_grant,
  input  logic snoop_kill,
  output logic load,
  output logic held,
  output logic evict_stall,
  output logic wb_req,
  output logic wb_fire,
  output logic snoop_hit
);
  wbb_state_e state_q, state_d;
  logic       grant_take;
  logic       fire_q, hit_q;

  assign held       = (state_q != ST_EMPTY);
  assign load       = evict_valid && (state_q == ST_EMPTY);
  assign grant_take = wb_grant && (state_q == ST_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EMPTY: if (load) state_d = ST_HOLD;
      ST_HOLD, ST_REQ: begin
        if (snoop_kill || grant_take) state_d = ST_EMPTY;
        else if (!miss_pending)       state_d = ST_REQ;
        else                          state_d = ST_HOLD;
      end
      default: state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_EMPTY;
      fire_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= grant_take && !snoop_kill;
      hit_q   <= snoop_kill;
    end
  end

  assign evict_stall = (state_q != ST_EMPTY);
  assign wb_req      = (state_q == ST_REQ);
  assign wb_fire     = fire_q;
  assign snoop_hit   = hit_q;

  // R4: a request only follows a cycle with the miss already sent
  a_r4_req_after_miss: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> $past(!miss_pending));
  // R5: a writeback strobe only follows an accepted grant
  a_r5_fire_follows_grant: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> $past(wb_grant && wb_req));
  // R8: a matching snoop wins over a simultaneous grant
  a_r8_snoop_beats_grant: assert property (@(posedge clk) disable iff (rst)
    (snoop_kill && wb_grant && wb_req) |=> (snoop_hit && !wb_fire));
  // R6: supplying the line releases the entry
  a_r6_hit_frees: assert property (@(posedge clk) disable iff (rst)
    snoop_hit |-> (!evict_stall && !wb_req));
  // R9: an unrequested grant does nothing
  a_r9_idle_grant: assert property (@(posedge clk) disable iff (rst)
    (wb_grant && !wb_req && !snoop_kill && held) |=> (!wb_fire && evict_stall));
endmodule

// File: rtl/wb_snoop_buffer.sv
module wb_snoop_buffer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int OFF_W     = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  output logic              evict_stall,
  input  logic              miss_pending,
  output logic              wb_req,
  input  logic              wb_grant,
  output logic              wb_fire,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_hit,
  output logic [DATA_W-1:0] snoop_data
);
  logic load, held, kill;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data;

  wbb_line_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_match (
    .entry_valid (held),
    .entry_addr  (held_addr),
    .probe_valid (snoop_valid),
    .probe_addr  (snoop_addr),
    .match       (kill)
  );

  wbb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_store (
    .clk         (clk),
    .load        (load),
    .load_addr   (evict_addr),
    .load_data   (evict_data),
    .supply      (kill),
    .held_addr   (held_addr),
    .held_data   (held_data),
    .supply_data (snoop_data)
  );

  wbb_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .evict_valid  (evict_valid),
    .miss_pending (miss_pending),
    .wb_grant     (wb_grant),
    .snoop_kill   (kill),
    .load         (load),
    .held         (held),
    .evict_stall  (evict_stall),
    .wb_req       (wb_req),
    .wb_fire      (wb_fire),
    .snoop_hit    (snoop_hit)
  );

  assign wb_addr = held_addr;
  assign wb_data = held_data;

  // R3: an eviction offered while occupied leaves the entry untouched
  a_r3_entry_kept: assert property (@(posedge clk) disable iff (rst)
    (evict_stall && evict_valid) |=> ($stable(wb_addr) && $stable(wb_data)));
  // R2: the stall covers the cycle after a capture
  a_r2_stall_after_load: assert property (@(posedge clk) disable iff (rst)
    (!evict_stall && evict_valid) |=> evict_stall);
endmodule

// File: tb/test_wb_snoop_buffer.sv
`timescale 1ns/1ps
module test_wb_snoop_buffer;
  localparam int AW = 8;
  localparam int LB = 4;
  localparam int DW = LB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic evict_stall;
  logic miss_pending = 1'b1;
  logic wb_req;
  logic wb_grant = 1'b0;
  logic wb_fire;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic snoop_hit;
  logic [DW-1:0] snoop_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wb_snoop_buffer #(.ADDR_W(AW), .LINE_BYTES(LB)) i_wb_snoop_buffer (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
    .evict_stall(evict_stall), .miss_pending(miss_pending),
    .wb_req(wb_req), .wb_grant(wb_grant), .wb_fire(wb_fire),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .snoop_hit(snoop_hit), .snoop_data(snoop_data)
  );

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return {a, a ^ 8'hA5, ~a, a + 8'd3};
  endfunction

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Capture a line; afterwards the entry is held (R2).
  task automatic load_line(input logic [AW-1:0] a);
    evict_valid = 1'b1; evict_addr = a; evict_data = line_of(a);
    tick();
    evict_valid = 1'b0;
  endtask

  // Release a held entry through a normal writeback and check it (R4, R5).
  task automatic drain(input logic [AW-1:0] a);
    miss_pending = 1'b0;
    tick();
    check(wb_req == 1'b1, "R4 req after miss sent", 64'(wb_req), 64'd1);
    wb_grant = 1'b1;
    tick();
    wb_grant = 1'b0;
    miss_pending = 1'b1;
    check(wb_fire == 1'b1, "R5 fire", 64'(wb_fire), 64'd1);
    check(wb_addr == align(a), "R5 addr", 64'(wb_addr), 64'(align(a)));
    check(wb_data == line_of(a), "R5 data", 64'(wb_data), 64'(line_of(a)));
    check(!evict_stall && !wb_req, "R5 released", {62'd0, evict_stall, wb_req}, 64'd0);
    tick();
    check(wb_fire == 1'b0, "R5 single pulse", 64'(wb_fire), 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] held_lines [4];
    held_lines[0] = 8'h00; held_lines[1] = 8'h5B;
    held_lines[2] = 8'hA6; held_lines[3] = 8'hFF;

    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(!evict_stall && !wb_req && !wb_fire && !snoop_hit, "R1 reset outputs",
          {60'd0, evict_stall, wb_req, wb_fire, snoop_hit}, 64'd0);

    // R7: snoop while empty
    snoop_valid = 1'b1; snoop_addr = 8'h40;
    tick();
    snoop_valid = 1'b0;
    check(!snoop_hit && !evict_stall, "R7 empty snoop", {62'd0, snoop_hit, evict_stall}, 64'd0);

    // R2 / R3 / R4: capture, refuse a second eviction, hold request while miss pending
    load_line(8'h37);
    check(evict_stall == 1'b1, "R2 stall after capture", 64'(evict_stall), 64'd1);
    evict_valid = 1'b1; evict_addr = 8'hC9; evict_data = line_of(8'hC9);
    repeat (4) begin
      tick();
      check(wb_req == 1'b0, "R4 no req while miss pending", 64'(wb_req), 64'd0);
      check(evict_stall == 1'b1, "R2 stall holds", 64'(evict_stall), 64'd1);
    end
    evict_valid = 1'b0;
    // R9: grant without a request
    wb_grant = 1'b1;
    tick();
    wb_grant = 1'b0;
    check(!wb_fire && evict_stall, "R9 idle grant", {62'd0, wb_fire, evict_stall}, 64'h1);
    // R3: the first line is still the one written back
    drain(8'h37);

    // R4: request drops again when miss_pending returns
    load_line(8'h12);
    miss_pending = 1'b0;
    tick();
    check(wb_req == 1'b1, "R4 req raised", 64'(wb_req), 64'd1);
    miss_pending = 1'b1;
    tick();
    check(wb_req == 1'b0, "R4 req withdrawn", 64'(wb_req), 64'd0);
    drain(8'h12);

    // R8: simultaneous grant and matching snoop
    load_line(8'h6D);
    miss_pending = 1'b0;
    tick();
    check(wb_req == 1'b1, "R8 setup req", 64'(wb_req), 64'd1);
    wb_grant = 1'b1; snoop_valid = 1'b1; snoop_addr = 8'h6E;
    tick();
    wb_grant = 1'b0; snoop_valid = 1'b0; miss_pending = 1'b1;
    check(snoop_hit && !wb_fire, "R8 snoop wins", {62'd0, snoop_hit, wb_fire}, 64'h2);
    check(snoop_data == line_of(8'h6D), "R8 data", 64'(snoop_data), 64'(line_of(8'h6D)));
    check(!evict_stall, "R8 released", 64'(evict_stall), 64'd0);
    tick();
    check(!wb_fire && !snoop_hit, "R8 no late fire", {62'd0, wb_fire, snoop_hit}, 64'd0);

    // R6 / R7: sweep every snoop address against several held lines
    foreach (held_lines[i]) begin
      for (int s = 0; s < 256; s++) begin
        logic [AW-1:0] h;
        logic [AW-1:0] sa;
        bit exp_hit;
        h = held_lines[i];
        sa = AW'(s);
        exp_hit = (sa[AW-1:2] == h[AW-1:2]);
        load_line(h ^ AW'(s & 3));
        snoop_valid = 1'b1; snoop_addr = sa;
        tick();
        snoop_valid = 1'b0;
        if (exp_hit) begin
          check(snoop_hit == 1'b1, "R6 hit on line match", 64'(snoop_hit), 64'd1);
          check(snoop_data == line_of(h ^ AW'(s & 3)), "R6 supplied data",
                64'(snoop_data), 64'(line_of(h ^ AW'(s & 3))));
          check(!evict_stall && !wb_req, "R6 entry released", {62'd0, evict_stall, wb_req}, 64'd0);
          tick();
          check(!wb_fire && !snoop_hit, "R6 no writeback", {62'd0, wb_fire, snoop_hit}, 64'd0);
        end else begin
          check(snoop_hit == 1'b0, "R7 miss on other line", 64'(snoop_hit), 64'd0);
          check(evict_stall == 1'b1, "R7 entry kept", 64'(evict_stall), 64'd1);
          drain(h ^ AW'(s & 3));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule